// File: doc/BRIEF.md
# Serial Command Block Scanner

This block owns a 64-byte command RAM that a host fills with a list of length-prefixed commands. When the host sets bit 0 of the final RAM byte, the scanner walks the RAM from offset 0. For each command it reads a transmit count and a receive count, and it streams the transmit bytes to the peripheral channel selected by a running channel counter. It then collects that channel's reply bytes into the RAM slots that follow the transmit bytes, and it merges any error flags into the stored receive count byte. When the walk ends, the scanner clears the final byte to tell the host that the results are ready.

Skip bytes let the host pad and align the list. A terminator byte ends the walk early. A zero byte is a one-byte null command that only advances the channel counter. The attached device decides what each command means. The scanner handles only framing, channel numbering, error marking and the start/finish handshake.

Top module: `cmd_block_scanner`

## Requirements
- R1: A pass starts only when bit 0 of RAM byte 63 is 1. While it is 0, the RAM is left unchanged whatever the other bits of that byte hold, and no channel traffic occurs.
- R2: When a pass ends, byte 63 reads 0x00 and `host_ready` returns high. After reset, every RAM byte reads 0x00.
- R3: A command is a byte t (1..127), then a byte r, then t bytes. Those t bytes go out in RAM order on `ch_tx_data`, one per cycle, with `ch_tx_last` marking the final byte. The reply bytes are stored from the RAM position right after them.
- R4: A t byte that has bit 7 set, other than 0xFE, is skipped. The next byte is then read as t.
- R5: A t byte of 0xFE ends the pass. Bytes after it are neither interpreted nor modified.
- R6: A t byte of 0x00 is a null command that occupies one byte. It produces no channel traffic and advances the channel counter.
- R7: The channel counter is 0 at the start of each pass and advances by one after every null or real command. `ch_sel` carries its value during transmission.
- R8: If the device reports `ch_absent`, the stored r byte gets bit 7 set (0x80). A command reached with the counter at 6 or more is not sent to any device and is also marked 0x80.
- R9: If the device returns a byte count different from r, or raises `ch_fmt_err`, the stored r byte gets bit 6 set (0x40). Returned bytes up to r are still stored, and any excess is dropped.
- R10: Only bits 5:0 of r give the reply count. The stored r byte is the error flags in bits 7:6 above those six bits.
- R11: After a command, scanning resumes at the byte after its r-byte reply region. A t or r position past offset 63 ends the pass. Transmit bytes past the RAM end are sent as 0x00, and replies past it are dropped.
- R12: `host_ready` is low for the whole pass, and host accesses made while it is low are ignored. A read accepted with `host_ready` high returns its data on `host_rdata` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 6 | Host RAM byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid one cycle after an accepted read |
| host_ready | output | 1 | High when idle and accepting host accesses |
| ch_tx_valid | output | 1 | A transmit byte is on `ch_tx_data` this cycle |
| ch_tx_data | output | 8 | Transmit byte to the selected channel |
| ch_tx_last | output | 1 | Final transmit byte of the command |
| ch_sel | output | 3 | Channel number of the current command |
| ch_rx_valid | input | 1 | Reply byte present on `ch_rx_data` |
| ch_rx_data | input | 8 | Reply byte from the device |
| ch_done | input | 1 | One-cycle end of the device response, after the last reply byte |
| ch_absent | input | 1 | With `ch_done`: no device on the channel |
| ch_fmt_err | input | 1 | With `ch_done`: device rejected the transmit count |

## Verification
A wrong pointer shows up at once when the RAM image is read back after a pass. Replies land one slot off, the next t is taken from inside a reply region, or bytes past a terminator change. A wrong channel count makes the reply bytes carry another channel's signature, or sends traffic for a command that should have been marked absent. Both effects are visible within the same pass. A semaphore fault shows as `host_ready` staying low until the watchdog fires, or as a pass starting when bit 0 was clear. A count or flag fault shows only in the stored r byte, so every r value from 0 to 9 is swept against a device that always returns four bytes.

// File: rtl/cmd_block_scanner.sv
module cmd_block_scanner #(
  parameter int NUM_CH = 6,
  parameter int AW     = 6,
  localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          host_ready,
  output logic          ch_tx_valid,
  output logic [7:0]    ch_tx_data,
  output logic          ch_tx_last,
  output logic [CW-1:0] ch_sel,
  input  logic          ch_rx_valid,
  input  logic [7:0]    ch_rx_data,
  input  logic          ch_done,
  input  logic          ch_absent,
  input  logic          ch_fmt_err
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 8;

  typedef enum logic [2:0] {S_IDLE, S_T, S_R, S_TX, S_RX, S_END} st_t;

  st_t           st;
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] ptr, rpos, nxt;
  logic [6:0]    tcnt, rcnt;
  logic [5:0]    rlen;
  logic [AW:0]   ch;
  logic [7:0]    rdata_q;

  wire       in_rng   = int'(ptr) < DEPTH;
  wire [7:0] cur      = in_rng ? mem[ptr[AW-1:0]] : 8'h00;
  wire       ch_ok    = int'(ch) < NUM_CH;
  wire [7:0] sem_byte = mem[DEPTH-1];
  wire       len_bad  = rcnt != {1'b0, rlen};

  assign host_ready  = st == S_IDLE;
  assign host_rdata  = rdata_q;
  assign ch_tx_valid = st == S_TX;
  assign ch_tx_data  = cur;
  assign ch_tx_last  = (st == S_TX) && (tcnt == 7'd1);
  assign ch_sel      = ch[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      rpos    <= '0;
      nxt     <= '0;
      tcnt    <= '0;
      rcnt    <= '0;
      rlen    <= '0;
      ch      <= '0;
      rdata_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      case (st)
        S_IDLE: begin
          if (host_req) begin
            if (host_we) mem[host_addr] <= host_wdata;
            else         rdata_q        <= mem[host_addr];
          end
          if (sem_byte[0]) begin
            st  <= S_T;
            ptr <= '0;
            ch  <= '0;
          end
        end
        S_T: begin
          if (!in_rng || cur == 8'hFE) st <= S_END;
          else if (cur[7]) ptr <= ptr + PW'(1);
          else if (cur == 8'h00) begin
            ch  <= ch + (AW+1)'(1);
            ptr <= ptr + PW'(1);
          end else begin
            tcnt <= cur[6:0];
            ptr  <= ptr + PW'(1);
            st   <= S_R;
          end
        end
        S_R: begin
          if (!in_rng) st <= S_END;
          else begin
            rpos <= ptr;
            rlen <= cur[5:0];
            rcnt <= '0;
            nxt  <= ptr + PW'(tcnt) + PW'(cur[5:0]) + PW'(1);
            if (ch_ok) begin
              ptr <= ptr + PW'(1);
              st  <= S_TX;
            end else begin
              mem[ptr[AW-1:0]] <= {2'b10, cur[5:0]};
              ptr <= ptr + PW'(tcnt) + PW'(cur[5:0]) + PW'(1);
              ch  <= ch + (AW+1)'(1);
              st  <= S_T;
            end
          end
        end
        S_TX: begin
          ptr  <= ptr + PW'(1);
          tcnt <= tcnt - 7'd1;
          if (tcnt == 7'd1) st <= S_RX;
        end
        S_RX: begin
          if (ch_done) begin
            mem[rpos[AW-1:0]] <= {ch_absent, !ch_absent && (ch_fmt_err || len_bad), rlen};
            ptr <= nxt;
            ch  <= ch + (AW+1)'(1);
            st  <= S_T;
          end else if (ch_rx_valid) begin
            if (rcnt < {1'b0, rlen}) begin
              if (in_rng) mem[ptr[AW-1:0]] <= ch_rx_data;
              ptr <= ptr + PW'(1);
            end
            if (rcnt != 7'h7F) rcnt <= rcnt + 7'd1;
          end
        end
        default: begin
          mem[DEPTH-1] <= 8'h00;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cmd_block_scanner_chk.sv
module cmd_block_scanner_chk #(
  parameter int NUM_CH = 6,
  parameter int CW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ready,
  input logic          ch_tx_valid,
  input logic          ch_tx_last,
  input logic [CW-1:0] ch_sel,
  input logic [7:0]    sem_byte
);
  a_r1_start_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready && sem_byte[0] |=> !host_ready);

  a_r2_sem_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> sem_byte == 8'h00);

  a_r3_tx_burst: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tx_valid && !ch_tx_last |=> ch_tx_valid && $stable(ch_sel));

  a_r3_tx_end: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tx_valid && ch_tx_last |=> !ch_tx_valid);

  a_r8_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tx_valid |-> int'(ch_sel) < NUM_CH);

  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> !ch_tx_valid);
endmodule

bind cmd_block_scanner cmd_block_scanner_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .host_ready(host_ready),
  .ch_tx_valid(ch_tx_valid),
  .ch_tx_last(ch_tx_last),
  .ch_sel(ch_sel),
  .sem_byte(sem_byte)
);

// File: tb/cmd_block_scanner_bench.sv
module cmd_block_scanner_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       host_req = 0, host_we = 0;
  logic [5:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       host_ready;
  logic       ch_tx_valid, ch_tx_last;
  logic [7:0] ch_tx_data;
  logic [2:0] ch_sel;
  logic       ch_rx_valid, ch_done, ch_absent, ch_fmt_err;
  logic [7:0] ch_rx_data;

  always #5 clk = ~clk;

  cmd_block_scanner u_cmd_block_scanner (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .ch_tx_valid(ch_tx_valid), .ch_tx_data(ch_tx_data), .ch_tx_last(ch_tx_last),
    .ch_sel(ch_sel), .ch_rx_valid(ch_rx_valid), .ch_rx_data(ch_rx_data),
    .ch_done(ch_done), .ch_absent(ch_absent), .ch_fmt_err(ch_fmt_err)
  );

  int total = 0, fails = 0;
  int dev_txn, dev_sum, exp_txn, exp_sum;
  bit dev_present [8];
  int dev_len [8];
  int dev_tx [8];
  logic [7:0] img  [64];
  logic [7:0] expm [64];

  function automatic logic [7:0] resp(int c, int k);
    return 8'((c << 4) + k + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  // device model: counts transmit bytes, replies with channel-tagged bytes
  initial begin
    int cnt, c;
    ch_rx_valid = 0; ch_rx_data = 0; ch_done = 0; ch_absent = 0; ch_fmt_err = 0;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n && ch_tx_valid) begin
        dev_sum += int'(ch_tx_data) + int'(ch_sel);
        cnt++;
        if (ch_tx_last) begin
          c = int'(ch_sel);
          dev_txn++;
          @(negedge clk);
          if (dev_present[c])
            for (int k = 0; k < dev_len[c]; k++) begin
              ch_rx_valid = 1; ch_rx_data = resp(c, k);
              @(negedge clk);
            end
          ch_rx_valid = 0;
          ch_done = 1;
          ch_absent = !dev_present[c];
          ch_fmt_err = dev_present[c] && (cnt != dev_tx[c]);
          @(negedge clk);
          ch_done = 0; ch_absent = 0; ch_fmt_err = 0;
          cnt = 0;
        end
      end
    end
  end

  task automatic hwrite(input int a, input logic [7:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = 6'(a); host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic hread(input int a, output logic [7:0] d);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = 6'(a);
    @(negedge clk);
    host_req = 0;
    d = host_rdata;
  endtask

  // reference walk of the command list, built from the requirements
  task automatic ref_scan();
    int p, ch, t, r, d, n;
    logic [7:0] err;
    p = 0; ch = 0;
    while (p < 64) begin
      t = int'(expm[p]);
      if (t == 'hFE) break;
      if (t >= 128) begin p++; continue; end
      if (t == 0) begin ch++; p++; continue; end
      if (p + 1 >= 64) break;
      r = int'(expm[p+1]) & 63;
      d = p + 2;
      if (ch >= 6) err = 8'h80;
      else begin
        exp_txn++;
        for (int i = 0; i < t; i++) exp_sum += ((d + i < 64) ? int'(expm[d+i]) : 0) + ch;
        if (!dev_present[ch]) err = 8'h80;
        else begin
          n = dev_len[ch];
          for (int k = 0; k < n && k < r; k++)
            if (d + t + k < 64) expm[d+t+k] = resp(ch, k);
          err = (n != r || t != dev_tx[ch]) ? 8'h40 : 8'h00;
        end
      end
      expm[p+1] = err | 8'(r);
      p = d + t + r;
      ch++;
    end
    expm[63] = 8'h00;
  endtask

  task automatic run_pass(input string tag, input bit poke);
    logic [7:0] d;
    for (int i = 0; i < 64; i++) expm[i] = img[i];
    exp_txn = 0; exp_sum = 0;
    if (img[63][0]) ref_scan();
    dev_txn = 0; dev_sum = 0;
    for (int i = 0; i < 64; i++) hwrite(i, img[i]);
    @(negedge clk);
    if (poke) begin
      chk({tag, " R12 busy during pass"}, int'(host_ready), 0);
      host_req = 1; host_we = 1; host_addr = 6'd40; host_wdata = 8'hEE;
      @(negedge clk);
      host_req = 0; host_we = 0;
    end
    while (!host_ready) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      hread(i, d);
      chk($sformatf("%s byte %0d", tag, i), int'(d), int'(expm[i]));
    end
    chk({tag, " R7 transactions"}, dev_txn, exp_txn);
    chk({tag, " R3 tx byte sum"}, dev_sum, exp_sum);
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 64; i++) img[i] = v;
  endtask

  task automatic devs(input bit p0, p1, p2, p3, p4, p5, input int len, input int tx);
    dev_present[0] = p0; dev_present[1] = p1; dev_present[2] = p2;
    dev_present[3] = p3; dev_present[4] = p4; dev_present[5] = p5;
    dev_present[6] = 0; dev_present[7] = 0;
    for (int i = 0; i < 8; i++) begin dev_len[i] = len; dev_tx[i] = tx; end
  endtask

  task automatic four_ports();
    fill(8'h00);
    for (int j = 0; j < 4; j++) begin
      img[j*8] = 8'hFF; img[j*8+1] = 8'h01; img[j*8+2] = 8'h04; img[j*8+3] = 8'h01;
      for (int k = 4; k < 8; k++) img[j*8+k] = 8'hFF;
    end
    img[32] = 8'hFE;
    img[40] = 8'h5A;
    img[63] = 8'h01;
  endtask

  initial begin
    logic [7:0] d;
    dev_txn = 0; dev_sum = 0;
    devs(1, 1, 1, 1, 1, 1, 4, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 ready after reset", int'(host_ready), 1);
    hread(63, d);
    chk("R2 byte 63 after reset", int'(d), 0);
    hread(17, d);
    chk("R2 byte 17 after reset", int'(d), 0);

    devs(1, 0, 1, 0, 1, 1, 4, 1);
    four_ports();
    run_pass("R3/R4/R5/R8 four ports", 0);
    four_ports();
    run_pass("R12 host poke ignored", 1);

    four_ports();
    img[63] = 8'h80;
    run_pass("R1 flag clear 0x80", 0);
    four_ports();
    img[63] = 8'h02;
    run_pass("R1 flag clear 0x02", 0);

    devs(1, 1, 1, 1, 1, 1, 3, 1);
    fill(8'h00);
    img[4] = 8'hFF; img[5] = 8'h01; img[6] = 8'h03; img[7] = 8'h00;
    for (int k = 8; k < 12; k++) img[k] = 8'hFF;
    img[12] = 8'hFE; img[20] = 8'h77; img[63] = 8'h01;
    run_pass("R6 null commands then ch4", 0);

    devs(1, 1, 1, 1, 1, 1, 4, 1);
    fill(8'h00);
    img[6] = 8'h01; img[7] = 8'h02; img[8] = 8'h07;
    img[9] = 8'h33; img[10] = 8'h33; img[11] = 8'hFE; img[63] = 8'h01;
    run_pass("R8/R7 channel 6", 0);

    for (int r = 0; r < 10; r++) begin
      devs(1, 1, 1, 1, 1, 1, 4, 1);
      fill(8'h55);
      img[0] = 8'h01;
      img[1] = 8'(r | ((r % 4) << 6));
      img[2] = 8'h01;
      img[3+r] = 8'hFE;
      img[63] = 8'h01;
      run_pass($sformatf("R9/R10 sweep r=%0d", r), 0);
    end

    devs(1, 1, 1, 1, 1, 1, 4, 2);
    fill(8'h00);
    img[0] = 8'h01; img[1] = 8'h04; img[2] = 8'h09; img[7] = 8'hFE; img[63] = 8'h01;
    run_pass("R9 tx count rejected", 0);

    devs(1, 1, 1, 1, 1, 1, 2, 5);
    fill(8'hFF);
    img[58] = 8'h05; img[59] = 8'h02; img[60] = 8'h11; img[61] = 8'h22; img[62] = 8'h33;
    img[63] = 8'h01;
    run_pass("R11 command past RAM end", 0);

    fill(8'hFF);
    img[63] = 8'h01;
    run_pass("R4/R11 all skip bytes", 0);

    summary();
  end
endmodule